// File: doc/BRIEF.md
# Receive Test Pattern Checker Statistics

This block measures the quality of a serial receive stream during link testing. Each received bit arrives with a valid strobe. The block compares the bit against a local reference, which is either a programmable static word repeated over and over or a PRBS-15 sequence. First it aligns that reference to the incoming data. After alignment it counts bit errors and the time spent in the aligned state, in units of an external 125 µs tick.

Software starts a measurement with a 0-to-1 transition of the receive enable. That transition clears both counters and restarts alignment. Dropping the enable stops the measurement, and the final counts stay readable until the next start. If the link degrades badly after alignment, the checker leaves sync and stops counting. Each counter is presented as a 32-bit read word.

Top module: `pattern_checker_stats`

## Requirements
- R1: After reset, `sync` is low and both read words are zero.
- R2: In each read word, the count sits in bits 23..0 and bits 31..24 read as zero.
- R3: A valid bit that mismatches the reference adds exactly one to the error count, visible the cycle after the strobe. This happens only while `sync` is high. Bits received before sync never add to the count.
- R4: The error count saturates at 0xFFFFFF (all ones at the configured width) and does not wrap.
- R5: The time count adds one for each `tick_125us` pulse seen while `sync` is high and `rx_en` is high. It saturates at all ones. Ticks seen at any other time have no effect.
- R6: Both counts read zero in the cycle after `rx_en` goes from 0 to 1. A steady high level of `rx_en` never clears them.
- R7: While `rx_en` is low, `sync` is low, and bits and ticks leave both counts unchanged, so the last results stay readable.
- R8: PRBS mode (`pat_sel`=1) uses x^15+x^14+1, with expected bit = state[14]^state[13] shifted into bit 0. The first 15 valid bits are loaded into the state. The next 32 bits must all match, so `sync` rises after the 47th valid bit of an error-free stream. A mismatch during those 32 bits restarts the loading.
- R9: Static mode (`pat_sel`=0) expects the 32-bit `static_word` most significant bit first, repeated. `sync` rises on the first valid bit that completes 32 consecutive received bits equal to any rotation of that word.
- R10: After sync, valid bits are grouped into consecutive 64-bit windows, starting at the first bit after sync. Eight errors within one window drop `sync` and stop all counting until the next enable edge. Seven errors per window keep sync.
- R11: `pat_sel` is sampled on the rising edge of `rx_en`. Changing it during a measurement has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up or soft) |
| rx_en | input | 1 | Receive enable; its rising edge starts a measurement |
| pat_sel | input | 1 | Reference select: 0 static word, 1 PRBS-15 |
| static_word | input | 32 | Static reference word, sent MSB first |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | Strobe marking `bit_in` valid |
| tick_125us | input | 1 | Single-cycle 125 µs time pulse |
| sync | output | 1 | Reference aligned and counting |
| err_word | output | 32 | Error count read word |
| time_word | output | 32 | Elapsed time read word |

## Verification
Some rules can be judged from one cycle to the next, and the assertions check these on every cycle. The error count steps by at most one and never moves without sync. Neither count moves while the enable is low. Time moves only on a tick. An enable edge zeroes both counts, and saturated values stay put. Other behaviour depends on the content of the stream and can only be shown by the bench's scenarios. These are the exact bit on which PRBS or static alignment is declared, the alignment at an arbitrary rotation, the seven-versus-eight error window decision and the freeze after loss of sync, and the mode being fixed at the start of a measurement.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HUNT   = 3'd1,
        ST_VERIFY = 3'd2,
        ST_LOCKED = 3'd3,
        ST_LOST   = 3'd4
    } chk_state_e;

    localparam logic MODE_STATIC = 1'b0;
    localparam logic MODE_PRBS   = 1'b1;

endpackage

// File: rtl/pcs_prbs_ref.sv
module pcs_prbs_ref #(
    parameter int LEN   = 15,
    parameter int TAP_A = 15,
    parameter int TAP_B = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic load,
    input  logic bit_in,
    output logic exp_bit
);

    logic [LEN-1:0] lfsr_d, lfsr_q;

    assign exp_bit = lfsr_q[TAP_A-1] ^ lfsr_q[TAP_B-1];

    always_comb begin
        lfsr_d = lfsr_q;
        if (adv) begin
            if (load) lfsr_d = {lfsr_q[LEN-2:0], bit_in};
            else      lfsr_d = {lfsr_q[LEN-2:0], exp_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= '0;
        else        lfsr_q <= lfsr_d;
    end

endmodule

// File: rtl/pcs_static_ref.sv
module pcs_static_ref #(
    parameter int PAT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAT_W-1:0] word,
    input  logic             clr,
    input  logic             adv,
    input  logic             hunt,
    input  logic             bit_in,
    output logic             exp_bit,
    output logic             found
);

    localparam int PW = $clog2(PAT_W);
    localparam int FW = $clog2(PAT_W + 1);

    typedef struct packed {
        logic [PAT_W-1:0] hist;
        logic [FW-1:0]    fill;
        logic [PW-1:0]    ptr;
    } st_t;

    st_t d, q;

    logic [PAT_W-1:0] hist_n;
    logic [PAT_W-1:0] hit;
    logic [PW-1:0]    sel;

    assign hist_n  = {q.hist[PAT_W-2:0], bit_in};
    assign exp_bit = word[PW'(PAT_W - 1) - q.ptr];

    for (genvar k = 0; k < PAT_W; k++) begin : g_rot
        logic [PAT_W-1:0] rot;
        assign rot    = (word << k) | (word >> (PAT_W - k));
        assign hit[k] = (hist_n == rot);
    end

    always_comb begin
        sel = '0;
        for (int k = PAT_W - 1; k >= 0; k--) begin
            if (hit[k]) sel = PW'(k);
        end
    end

    assign found = adv && hunt && (q.fill >= FW'(PAT_W - 1)) && (|hit);

    always_comb begin
        d = q;
        if (clr) begin
            d.hist = '0;
            d.fill = '0;
            d.ptr  = '0;
        end else if (adv) begin
            if (hunt) begin
                d.hist = hist_n;
                if (q.fill < FW'(PAT_W)) d.fill = q.fill + 1'b1;
                if (found) d.ptr = sel;
            end else begin
                d.ptr = (q.ptr == PW'(PAT_W - 1)) ? '0 : q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/pcs_sat_counter.sv
module pcs_sat_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                     cnt_d = '0;
        else if (inc && ~&cnt_q)     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/pattern_checker_stats.sv
module pattern_checker_stats
    import pcs_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int RD_W        = 32,
    parameter int PAT_W       = 32,
    parameter int PRBS_LEN    = 15,
    parameter int SYNC_RUN    = 32,
    parameter int WIN_LEN     = 64,
    parameter int WIN_ERR_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             pat_sel,
    input  logic [PAT_W-1:0] static_word,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             tick_125us,
    output logic             sync,
    output logic [RD_W-1:0]  err_word,
    output logic [RD_W-1:0]  time_word
);

    localparam int HUNT_MAX = (SYNC_RUN > PRBS_LEN) ? SYNC_RUN : PRBS_LEN;
    localparam int CW       = $clog2(HUNT_MAX + 1);
    localparam int WW       = $clog2(WIN_LEN);
    localparam int EW       = $clog2(WIN_ERR_MAX + 1);
    localparam int PAD      = RD_W - CNT_W;

    typedef struct packed {
        chk_state_e     st;
        logic           mode;
        logic           en;
        logic [CW-1:0]  run;
        logic [WW-1:0]  wcnt;
        logic [EW-1:0]  werr;
    } ctl_t;

    ctl_t d, q;

    logic             rise;
    logic             prbs_exp, stat_exp, ref_exp, mis;
    logic             stat_found;
    logic             adv;
    logic             err_inc, time_inc;
    logic [EW-1:0]    werr_n;
    logic [CNT_W-1:0] err_cnt, time_cnt;

    assign rise    = rx_en && !q.en;
    assign adv     = bit_vld && rx_en;
    assign ref_exp = (q.mode == MODE_PRBS) ? prbs_exp : stat_exp;
    assign mis     = bit_in ^ ref_exp;
    assign werr_n  = q.werr + EW'(mis);

    pcs_prbs_ref #(
        .LEN   (PRBS_LEN),
        .TAP_A (15),
        .TAP_B (14)
    ) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv && (q.mode == MODE_PRBS)),
        .load    (q.st == ST_HUNT),
        .bit_in  (bit_in),
        .exp_bit (prbs_exp)
    );

    pcs_static_ref #(
        .PAT_W (PAT_W)
    ) u_static (
        .clk     (clk),
        .rst_n   (rst_n),
        .word    (static_word),
        .clr     (rise),
        .adv     (adv && (q.mode == MODE_STATIC)),
        .hunt    (q.st == ST_HUNT),
        .bit_in  (bit_in),
        .exp_bit (stat_exp),
        .found   (stat_found)
    );

    always_comb begin
        d    = q;
        d.en = rx_en;
        if (rise) begin
            d.st   = ST_HUNT;
            d.mode = pat_sel;
            d.run  = '0;
            d.wcnt = '0;
            d.werr = '0;
        end else if (!rx_en) begin
            d.st = ST_IDLE;
        end else if (bit_vld) begin
            unique case (q.st)
                ST_HUNT: begin
                    if (q.mode == MODE_PRBS) begin
                        if (q.run == CW'(PRBS_LEN - 1)) begin
                            d.st  = ST_VERIFY;
                            d.run = '0;
                        end else begin
                            d.run = q.run + 1'b1;
                        end
                    end else if (stat_found) begin
                        d.st   = ST_LOCKED;
                        d.wcnt = '0;
                        d.werr = '0;
                    end
                end
                ST_VERIFY: begin
                    if (mis) begin
                        d.st  = ST_HUNT;
                        d.run = '0;
                    end else if (q.run == CW'(SYNC_RUN - 1)) begin
                        d.st   = ST_LOCKED;
                        d.wcnt = '0;
                        d.werr = '0;
                    end else begin
                        d.run = q.run + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (werr_n >= EW'(WIN_ERR_MAX)) begin
                        d.st = ST_LOST;
                    end else if (q.wcnt == WW'(WIN_LEN - 1)) begin
                        d.wcnt = '0;
                        d.werr = '0;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                        d.werr = werr_n;
                    end
                end
                default: d.st = q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, mode: MODE_STATIC, en: 1'b0,
                   run: '0, wcnt: '0, werr: '0};
        end else begin
            q <= d;
        end
    end

    assign err_inc  = rx_en && (q.st == ST_LOCKED) && bit_vld && mis;
    assign time_inc = rx_en && (q.st == ST_LOCKED) && tick_125us;

    pcs_sat_counter #(.W(CNT_W)) u_err_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rise),
        .inc   (err_inc),
        .cnt   (err_cnt)
    );

    pcs_sat_counter #(.W(CNT_W)) u_time_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rise),
        .inc   (time_inc),
        .cnt   (time_cnt)
    );

    assign sync      = (q.st == ST_LOCKED);
    assign err_word  = {{PAD{1'b0}}, err_cnt};
    assign time_word = {{PAD{1'b0}}, time_cnt};

endmodule

// File: rtl/pattern_checker_stats_chk.sv
module pattern_checker_stats_chk #(
    parameter int CNT_W = 24,
    parameter int RD_W  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_en,
    input logic            tick_125us,
    input logic            sync,
    input logic [RD_W-1:0] err_word,
    input logic [RD_W-1:0] time_word
);

    localparam logic [RD_W-1:0] TOP = {{(RD_W - CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic en_prev;
    logic start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= rx_en;
    end

    assign start = rx_en && !en_prev;

    // R3
    err_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && !start) |=> $stable(err_word));

    // R3
    err_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (err_word == $past(err_word)) || (err_word == $past(err_word) + 1'b1));

    // R4
    err_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_word == TOP && !start) |=> (err_word == TOP));

    // R5
    time_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_125us && !start) |=> $stable(time_word));

    // R5
    time_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_word == TOP && !start) |=> (time_word == TOP));

    // R6
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (err_word == '0) && (time_word == '0));

    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(err_word) && $stable(time_word));

    // R7
    sync_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> en_prev);

endmodule

bind pattern_checker_stats pattern_checker_stats_chk #(
    .CNT_W (CNT_W),
    .RD_W  (RD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .tick_125us (tick_125us),
    .sync       (sync),
    .err_word   (err_word),
    .time_word  (time_word)
);

// File: tb/tb_pattern_checker_stats.sv
`timescale 1ns/1ps
module tb_pattern_checker_stats;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_en;
    logic        pat_sel;
    logic [31:0] sword;
    logic        bit_in;
    logic        bit_vld;
    logic        tick;
    logic        sync, sat_sync;
    logic [31:0] err_word, time_word, sat_err, sat_time;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [14:0] g;
    int sp;

    always #2 clk = ~clk;

    pattern_checker_stats dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .pat_sel(pat_sel),
        .static_word(sword), .bit_in(bit_in), .bit_vld(bit_vld),
        .tick_125us(tick), .sync(sync), .err_word(err_word), .time_word(time_word)
    );

    pattern_checker_stats #(.CNT_W(4)) dut_sat (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .pat_sel(pat_sel),
        .static_word(sword), .bit_in(bit_in), .bit_vld(bit_vld),
        .tick_125us(tick), .sync(sat_sync), .err_word(sat_err), .time_word(sat_time)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bit_vld = 1'b0;
        tick    = 1'b0;
    endtask

    task automatic send(logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        tick    = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            tick    = 1'b1;
        end
        idle();
    endtask

    task automatic prbs_bits(int n, int nerr, int stride);
        for (int i = 0; i < n; i++) begin
            logic b;
            logic flip;
            b    = g[14] ^ g[13];
            g    = {g[13:0], b};
            flip = ((i % stride) == 0) && ((i / stride) < nerr);
            send(b ^ flip);
        end
        idle();
    endtask

    task automatic static_bits(int n, int nerr, int stride);
        for (int i = 0; i < n; i++) begin
            logic b;
            logic flip;
            b    = sword[31 - sp];
            sp   = (sp + 1) % 32;
            flip = ((i % stride) == 0) && ((i / stride) < nerr);
            send(b ^ flip);
        end
        idle();
    endtask

    task automatic start_rx(logic mode);
        @(negedge clk);
        rx_en   = 1'b0;
        bit_vld = 1'b0;
        @(negedge clk);
        pat_sel = mode;
        rx_en   = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 sync", sync, 0);
        chk("R1 err", err_word, 0);
        chk("R1 time", time_word, 0);
    endtask

    task automatic t_prbs_lock();
        g = 15'h0001;
        start_rx(1'b1);
        prbs_bits(46, 0, 1);
        chk("R8 no sync at 46", sync, 0);
        ticks(2);
        chk("R5 tick before sync ignored", time_word, 0);
        prbs_bits(1, 0, 1);
        chk("R8 sync at 47", sync, 1);
        chk("R3 no errors before sync", err_word, 0);
        ticks(3);
        chk("R5 three ticks", time_word, 3);
    endtask

    task automatic t_prbs_errors();
        prbs_bits(64, 7, 9);
        chk("R3 seven errors", err_word, 7);
        chk("R10 seven keep sync", sync, 1);
        prbs_bits(64, 7, 9);
        chk("R3 fourteen errors", err_word, 14);
        chk("R10 second window keeps sync", sync, 1);
        chk("R2 upper bits zero", {24'h0, err_word[31:24]}, 0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        rx_en = 1'b0;
        prbs_bits(10, 5, 2);
        ticks(2);
        chk("R7 err held", err_word, 14);
        chk("R7 time held", time_word, 3);
        chk("R7 sync low", sync, 0);
        start_rx(1'b1);
        chk("R6 err cleared on edge", err_word, 0);
        chk("R6 time cleared on edge", time_word, 0);
    endtask

    task automatic t_drop();
        prbs_bits(47, 0, 1);
        chk("R8 relock", sync, 1);
        prbs_bits(20, 8, 2);
        chk("R10 eight errors drop sync", sync, 0);
        chk("R10 count at drop", err_word, 8);
        prbs_bits(30, 10, 3);
        ticks(2);
        chk("R10 frozen err", err_word, 8);
        chk("R10 frozen time", time_word, 0);
    endtask

    task automatic t_static();
        sword = 32'hA5C3_1E0F;
        sp    = 7;
        start_rx(1'b0);
        static_bits(31, 0, 1);
        chk("R9 no sync at 31", sync, 0);
        static_bits(1, 0, 1);
        chk("R9 sync at rotation 7", sync, 1);
        static_bits(10, 2, 4);
        chk("R3 static errors", err_word, 2);
        @(negedge clk);
        pat_sel = 1'b1;
        static_bits(40, 0, 1);
        chk("R11 mode change ignored err", err_word, 2);
        chk("R11 mode change ignored sync", sync, 1);
    endtask

    task automatic t_sat();
        g = 15'h0001;
        start_rx(1'b1);
        prbs_bits(47, 0, 1);
        for (int w = 0; w < 3; w++) prbs_bits(64, 7, 9);
        ticks(20);
        chk("R4 narrow err saturates", sat_err, 15);
        chk("R5 narrow time saturates", sat_time, 15);
        chk("R4 wide err counts on", err_word, 21);
        chk("R5 wide time counts on", time_word, 20);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        rx_en   = 1'b0;
        pat_sel = 1'b0;
        sword   = '0;
        bit_in  = 1'b0;
        bit_vld = 1'b0;
        tick    = 1'b0;
        g       = 15'h0001;
        sp      = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prbs_lock();
        t_prbs_errors();
        t_hold();
        t_drop();
        t_static();
        t_sat();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule